// File: doc/BRIEF.md
# Viewport-Indexed Address Translation Unit

This block keeps two banks of address translation regions, one for outbound traffic and one for inbound traffic. Software never sees all the regions at once. It writes a viewport register that names a direction and a region number. After that, a small window of seven region registers reads and writes that one region. Each region has a 64-bit base, a 32-bit limit that shares the upper half of the base, a 64-bit target and two control words. The control words carry a type code and an enable bit.

The lookup side is combinational. A requester presents a 64-bit address and a direction. The block searches the enabled regions of that direction for a window that contains the address. It returns a hit flag, the winning region number, that region's type code and the translated address. When no region contains the address, the address is returned unchanged.

The two directions commit edits in different ways. An outbound edit changes translation in the cycle after the write. An inbound edit is only staged, and it reaches the lookup path when software next writes the viewport with a value that differs from the one it holds.

Top module: `xlat_unit`

## Requirements
- R1: After a synchronous reset, every register reads zero and no lookup hits in either direction.
- R2: A write to the viewport (select code 0) keeps bit 31 as the direction (0 outbound, 1 inbound) and bits 3:0 as the region number. Reading the viewport returns those bits in place with every other bit zero.
- R3: Region select codes are 1 base low, 2 base high, 3 limit, 4 target low, 5 target high, 6 control 1 and 7 control 2. Each reads and writes the region named by the viewport, and a read returns the staged value even when that value is not yet active.
- R4: A region matches an address A when {base high, base low} <= A <= {base high, limit}. Both ends of the window are included.
- R5: A region whose control 2 bit 31 is clear never matches.
- R6: On a hit, lk_type carries bits 3:0 of the winning region's control 1. Upper bits of control 1 have no effect.
- R7: On a hit, the translated address is {target high, target low} + (A − {base high, base low}), taken modulo 2^64.
- R8: A write to an outbound region register takes effect for lookups in the cycle after the write.
- R9: An inbound region write has no effect on lookups until the viewport is written with a value different from the value it holds. Rewriting the same viewport value commits nothing.
- R10: When several enabled regions of a direction match, the lowest-numbered region wins and lk_region reports its number.
- R11: On a miss, lk_hit is 0, lk_type is 0 and lk_addr_out equals lk_addr.
- R12: A lookup consults only the regions of the direction that lk_inbound selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 viewport, 1..7 region fields) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_inbound | input | 1 | Lookup direction, 1 inbound |
| lk_addr | input | 64 | Address to translate |
| lk_hit | output | 1 | A region matched |
| lk_region | output | IDX_W (4) | Winning region number |
| lk_type | output | 4 | Type code of the winning region |
| lk_addr_out | output | 64 | Translated or passed-through address |

## Verification
The lookup is swept over every outbound region, probing the base, an interior point, the limit, one past the limit and one below the base. These probes separate an inclusive compare from an exclusive one at each end. One region is disabled, one uses a non-zero upper base, and one overlaps a lower-numbered window, so the sweep also tells the enable test, the 64-bit compare and the priority order apart. Inbound edits are probed before a viewport change, after a same-value rewrite and after a real change, which distinguishes staged state from active state. The same addresses are looked up in the opposite direction to show that the two banks do not leak into each other.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 2 * REG_W;
    localparam int VP_IDX_W = 4;
    localparam int TYPE_W   = 4;
    localparam int EN_BIT   = 31;
    localparam int DIR_BIT  = 31;

    typedef enum logic [2:0] {
        SEL_VIEWPORT = 3'd0,
        SEL_BASE_LO  = 3'd1,
        SEL_BASE_HI  = 3'd2,
        SEL_LIMIT    = 3'd3,
        SEL_TGT_LO   = 3'd4,
        SEL_TGT_HI   = 3'd5,
        SEL_CTRL1    = 3'd6,
        SEL_CTRL2    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] base_lo;
        logic [REG_W-1:0] base_hi;
        logic [REG_W-1:0] limit;
        logic [REG_W-1:0] tgt_lo;
        logic [REG_W-1:0] tgt_hi;
        logic [REG_W-1:0] ctrl1;
        logic [REG_W-1:0] ctrl2;
    } region_t;

    typedef struct packed {
        logic                inbound;
        logic [VP_IDX_W-1:0] idx;
    } viewport_t;

    function automatic logic [REG_W-1:0] vp_pack(viewport_t v);
        return {v.inbound, {(REG_W-1-VP_IDX_W){1'b0}}, v.idx};
    endfunction

    function automatic viewport_t vp_unpack(logic [REG_W-1:0] d);
        viewport_t v;
        v.inbound = d[DIR_BIT];
        v.idx     = d[VP_IDX_W-1:0];
        return v;
    endfunction

    function automatic logic [REG_W-1:0] field_get(region_t r, logic [2:0] sel);
        case (sel)
            SEL_BASE_LO: return r.base_lo;
            SEL_BASE_HI: return r.base_hi;
            SEL_LIMIT:   return r.limit;
            SEL_TGT_LO:  return r.tgt_lo;
            SEL_TGT_HI:  return r.tgt_hi;
            SEL_CTRL1:   return r.ctrl1;
            SEL_CTRL2:   return r.ctrl2;
            default:     return '0;
        endcase
    endfunction

    function automatic region_t field_set(region_t r, logic [2:0] sel, logic [REG_W-1:0] d);
        region_t n;
        n = r;
        case (sel)
            SEL_BASE_LO: n.base_lo = d;
            SEL_BASE_HI: n.base_hi = d;
            SEL_LIMIT:   n.limit   = d;
            SEL_TGT_LO:  n.tgt_lo  = d;
            SEL_TGT_HI:  n.tgt_hi  = d;
            SEL_CTRL1:   n.ctrl1   = d;
            SEL_CTRL2:   n.ctrl2   = d;
            default:     n = r;
        endcase
        return n;
    endfunction

    function automatic logic region_hit(region_t r, logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        lo = {r.base_hi, r.base_lo};
        hi = {r.base_hi, r.limit};
        return r.ctrl2[EN_BIT] && (a >= lo) && (a <= hi);
    endfunction

    function automatic logic [ADDR_W-1:0] region_xlat(region_t r, logic [ADDR_W-1:0] a);
        return {r.tgt_hi, r.tgt_lo} + (a - {r.base_hi, r.base_lo});
    endfunction
endpackage

// File: rtl/xlat_viewport.sv
`timescale 1ns/1ps
module xlat_viewport
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output viewport_t        vp,
    output logic             commit
);
    viewport_t nxt;

    assign nxt    = vp_unpack(wdata);
    assign commit = wr && (nxt != vp);

    always_ff @(posedge clk) begin
        if (rst)     vp <= '0;
        else if (wr) vp <= nxt;
    end
endmodule

// File: rtl/xlat_region_bank.sv
`timescale 1ns/1ps
module xlat_region_bank
    import xlat_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter bit HOLD        = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [VP_IDX_W-1:0] wr_idx,
    input  logic [2:0]          wr_sel,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                commit,
    output region_t             stg_o [NUM_REGIONS],
    output region_t             act_o [NUM_REGIONS]
);
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (rst)
                stg_o[i] <= '0;
            else if (wr_en && (int'(wr_idx) == i))
                stg_o[i] <= field_set(stg_o[i], wr_sel, wr_data);
        end
    end

    generate
        if (HOLD) begin : g_hold
            always_ff @(posedge clk) begin
                for (int i = 0; i < NUM_REGIONS; i++) begin
                    if (rst)         act_o[i] <= '0;
                    else if (commit) act_o[i] <= stg_o[i];
                end
            end
        end else begin : g_direct
            for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_pass
                assign act_o[g] = stg_o[g];
            end
        end
    endgenerate
endmodule

// File: rtl/xlat_matcher.sv
`timescale 1ns/1ps
module xlat_matcher
    import xlat_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  region_t             rg [NUM_REGIONS],
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [IDX_W-1:0]    idx,
    output logic [TYPE_W-1:0]   typ,
    output logic [ADDR_W-1:0]   addr_out
);
    logic [NUM_REGIONS-1:0] hv;
    region_t                win;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        assign hv[g] = region_hit(rg[g], addr);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
        win      = rg[idx];
        typ      = hit ? win.ctrl1[TYPE_W-1:0] : '0;
        addr_out = hit ? region_xlat(win, addr) : addr;
    end
endmodule

// File: rtl/xlat_unit.sv
`timescale 1ns/1ps
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [2:0]          reg_sel,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                lk_inbound,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic                lk_hit,
    output logic [IDX_W-1:0]    lk_region,
    output logic [TYPE_W-1:0]   lk_type,
    output logic [ADDR_W-1:0]   lk_addr_out
);
    viewport_t vp;
    logic      commit;
    logic      vp_wr;
    logic      idx_ok;
    logic      region_wr;

    region_t out_stg [NUM_REGIONS];
    region_t out_act [NUM_REGIONS];
    region_t in_stg  [NUM_REGIONS];
    region_t in_act  [NUM_REGIONS];

    assign vp_wr     = reg_we && (reg_sel == SEL_VIEWPORT);
    assign idx_ok    = int'(vp.idx) < NUM_REGIONS;
    assign region_wr = reg_we && (reg_sel != SEL_VIEWPORT) && idx_ok;

    xlat_viewport vp_i (
        .clk(clk), .rst(rst), .wr(vp_wr), .wdata(reg_wdata),
        .vp(vp), .commit(commit)
    );

    xlat_region_bank #(.NUM_REGIONS(NUM_REGIONS), .HOLD(1'b0)) out_bank_i (
        .clk(clk), .rst(rst), .wr_en(region_wr && !vp.inbound),
        .wr_idx(vp.idx), .wr_sel(reg_sel), .wr_data(reg_wdata),
        .commit(1'b0), .stg_o(out_stg), .act_o(out_act)
    );

    xlat_region_bank #(.NUM_REGIONS(NUM_REGIONS), .HOLD(1'b1)) in_bank_i (
        .clk(clk), .rst(rst), .wr_en(region_wr && vp.inbound),
        .wr_idx(vp.idx), .wr_sel(reg_sel), .wr_data(reg_wdata),
        .commit(commit), .stg_o(in_stg), .act_o(in_act)
    );

    region_t cur;
    always_comb begin
        cur = '0;
        if (idx_ok) cur = vp.inbound ? in_stg[vp.idx[IDX_W-1:0]] : out_stg[vp.idx[IDX_W-1:0]];
        reg_rdata = (reg_sel == SEL_VIEWPORT) ? vp_pack(vp) : field_get(cur, reg_sel);
    end

    logic               o_hit, i_hit;
    logic [IDX_W-1:0]   o_idx, i_idx;
    logic [TYPE_W-1:0]  o_typ, i_typ;
    logic [ADDR_W-1:0]  o_addr, i_addr;

    xlat_matcher #(.NUM_REGIONS(NUM_REGIONS)) out_match_i (
        .rg(out_act), .addr(lk_addr), .hit(o_hit), .idx(o_idx), .typ(o_typ), .addr_out(o_addr)
    );

    xlat_matcher #(.NUM_REGIONS(NUM_REGIONS)) in_match_i (
        .rg(in_act), .addr(lk_addr), .hit(i_hit), .idx(i_idx), .typ(i_typ), .addr_out(i_addr)
    );

    assign lk_hit      = lk_inbound ? i_hit  : o_hit;
    assign lk_region   = lk_inbound ? i_idx  : o_idx;
    assign lk_type     = lk_inbound ? i_typ  : o_typ;
    assign lk_addr_out = lk_inbound ? i_addr : o_addr;
endmodule

// File: rtl/xlat_unit_chk.sv
`timescale 1ns/1ps
module xlat_unit_chk
    import xlat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic              lk_inbound,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              lk_hit,
    input logic [TYPE_W-1:0] lk_type,
    input logic [ADDR_W-1:0] lk_addr_out
);
    logic vp_wr;
    assign vp_wr = reg_we && (reg_sel == SEL_VIEWPORT);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    assert_miss_passthru_R11: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_addr_out == lk_addr) && (lk_type == '0));

    assert_out_steady_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !lk_inbound && $stable(lk_inbound) && $stable(lk_addr) && !$past(reg_we))
        |-> $stable(lk_hit) && $stable(lk_addr_out) && $stable(lk_type));

    assert_in_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && lk_inbound && $stable(lk_inbound) && $stable(lk_addr) && !$past(vp_wr))
        |-> $stable(lk_hit) && $stable(lk_addr_out) && $stable(lk_type));
endmodule

bind xlat_unit xlat_unit_chk chk_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .lk_inbound(lk_inbound), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_type(lk_type), .lk_addr_out(lk_addr_out)
);

// File: tb/xlat_unit_tb_top.sv
`timescale 1ns/1ps
module xlat_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_inbound = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        lk_hit;
    logic [3:0]  lk_region;
    logic [3:0]  lk_type;
    logic [63:0] lk_addr_out;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    xlat_unit dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_inbound(lk_inbound), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_region(lk_region), .lk_type(lk_type), .lk_addr_out(lk_addr_out)
    );

    logic [31:0] m_stg [0:1][0:15][0:7];
    logic [31:0] m_act [0:15][0:7];
    logic [31:0] m_vp;

    task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        logic [31:0] nv;
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (sel == 3'd0) begin
            nv = {d[31], 27'b0, d[3:0]};
            if (nv != m_vp)
                for (int i = 0; i < 16; i++)
                    for (int k = 0; k < 8; k++) m_act[i][k] = m_stg[1][i][k];
            m_vp = nv;
        end else begin
            m_stg[m_vp[31]][m_vp[3:0]][sel] = d;
        end
    endtask

    task automatic rd(logic [2:0] sel, string tag);
        logic [31:0] e;
        e = (sel == 3'd0) ? m_vp : m_stg[m_vp[31]][m_vp[3:0]][sel];
        reg_sel = sel;
        #1;
        chk(tag, {48'b0, reg_rdata}, {48'b0, e});
    endtask

    function automatic logic [79:0] model_lk(bit dir, logic [63:0] a);
        logic [79:0] res;
        logic [31:0] f [0:7];
        logic [63:0] b, l;
        res = {7'b0, 1'b0, 4'b0, 4'b0, a};
        for (int i = 15; i >= 0; i--) begin
            for (int k = 0; k < 8; k++) f[k] = dir ? m_act[i][k] : m_stg[0][i][k];
            b = {f[2], f[1]};
            l = {f[2], f[3]};
            if (f[7][31] && a >= b && a <= l)
                res = {7'b0, 1'b1, 4'(i), f[6][3:0], {f[5], f[4]} + (a - b)};
        end
        return res;
    endfunction

    task automatic lk(bit dir, logic [63:0] a, string tag);
        @(negedge clk);
        lk_inbound = dir; lk_addr = a;
        #1;
        chk(tag, {7'b0, lk_hit, lk_region, lk_type, lk_addr_out}, model_lk(dir, a));
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        logic [63:0] b, l;
        m_vp = '0;
        for (int d = 0; d < 2; d++)
            for (int i = 0; i < 16; i++)
                for (int k = 0; k < 8; k++) begin
                    m_stg[d][i][k] = '0;
                    if (d == 0) m_act[i][k] = '0;
                end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: registers clear, lookups miss (R11 passthrough)
        for (int s = 0; s < 8; s++) rd(3'(s), "R1 reset readback");
        lk(1'b0, 64'h0, "R1 out miss");
        lk(1'b1, 64'h1234_5678, "R1 in miss");

        // Program outbound bank; region 5 disabled (R5), 7 upper base (R4), 13 overlaps 2 (R10)
        for (int i = 0; i < 16; i++) begin
            logic [31:0] bl;
            bl = 32'h1000_0000 + 32'(i) * 32'h0010_0000;
            if (i == 13) bl = 32'h1020_8000;
            wr(3'd0, 32'(i));
            wr(3'd1, bl);
            wr(3'd2, (i == 7) ? 32'h1 : 32'h0);
            wr(3'd3, bl + 32'h0000_FFFF);
            wr(3'd4, 32'(i) * 32'h0001_0000);
            wr(3'd5, 32'hA000_0000 | 32'(i));
            wr(3'd6, 32'hF0 | 32'(i));
            wr(3'd7, (i == 5) ? 32'h7FFF_FFFF : 32'h8000_0000);
        end

        // R4 R5 R6 R7 R10 sweep across every outbound region
        for (int i = 0; i < 16; i++) begin
            b = {m_stg[0][i][2], m_stg[0][i][1]};
            l = {m_stg[0][i][2], m_stg[0][i][3]};
            lk(1'b0, b,          "R4 base edge");
            lk(1'b0, b + 64'h7FFF, "R7 interior");
            lk(1'b0, l,          "R4 limit edge");
            lk(1'b0, l + 64'h1,  "R4 past limit");
            lk(1'b0, b - 64'h1,  "R4 below base");
            lk(1'b1, b,          "R12 inbound isolation");
        end
        lk(1'b0, 64'h1020_9000, "R10 overlap lowest wins");
        lk(1'b0, 64'h1000_0000_1070_0000, "R5 R11 disabled-region pattern");

        // R3 staged readback
        for (int i = 0; i < 16; i += 5) begin
            wr(3'd0, 32'(i));
            for (int s = 1; s < 8; s++) rd(3'(s), "R3 readback");
        end

        // R8 outbound edits act next cycle
        wr(3'd0, 32'd4);
        wr(3'd1, 32'h2000_0000);
        lk(1'b0, 64'h1040_0010, "R8 old window gone");
        lk(1'b0, 64'h2000_0010, "R8 new base, old limit");
        wr(3'd3, 32'h2000_0FFF);
        lk(1'b0, 64'h2000_0010, "R8 new window");

        // R9 inbound hold semantics
        wr(3'd0, 32'h8000_0003);
        wr(3'd1, 32'h4000_0000);
        wr(3'd3, 32'h4000_FFFF);
        wr(3'd5, 32'h0000_0055);
        wr(3'd6, 32'h0000_0009);
        wr(3'd7, 32'h8000_0000);
        rd(3'd6, "R3 pending readback");
        lk(1'b1, 64'h4000_0100, "R9 pending not active");
        wr(3'd0, 32'h8000_0003);
        lk(1'b1, 64'h4000_0100, "R9 same value no commit");
        wr(3'd0, 32'h8000_0004);
        lk(1'b1, 64'h4000_0100, "R9 commit on change");
        lk(1'b0, 64'h4000_0100, "R12 outbound unaffected");
        wr(3'd0, 32'h8000_0003);
        wr(3'd1, 32'h4000_8000);
        lk(1'b1, 64'h4000_0100, "R9 old inbound base kept");
        wr(3'd0, 32'h0000_0000);
        lk(1'b1, 64'h4000_0100, "R9 edited base committed");
        lk(1'b1, 64'h4000_8000, "R9 new inbound base");

        // R2 viewport readback masking
        wr(3'd0, 32'hFFFF_FFF6);
        rd(3'd0, "R2 inbound viewport");
        wr(3'd0, 32'h7FFF_FFF2);
        rd(3'd0, "R2 outbound viewport");
        rd(3'd6, "R2 selects outbound region 2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule